// File: doc/BRIEF.md
# Rate-4 Fifth-Order CIC Decimator

This block reduces the sample rate of one real channel of a digital downconverter by four. Signed 18-bit samples arrive with a valid strobe. Each accepted sample runs through a cascade of five running-sum (integrator) stages at the full input rate. One in every four integrated values is kept, and the kept value runs through five first-difference (comb) stages. The comb stages step only when a kept value arrives, so each one has at least four clock cycles to settle. The result is scaled back to 18 bits and presented with a one-cycle valid pulse.

The block is meant for a fast clock. The input sample is registered before the first integrator, and every integrator and comb stage has its own register with its own valid bit. No stage therefore has more than one adder between flops. The internal word is 28 bits wide, which is 18 + 5·log2(4), and the integrators wrap in two's complement. The cascade gain is 4^5 = 1024, and the output takes bits 27:10 of the last comb result to remove it. The asynchronous reset is re-timed inside the block before it reaches the datapath.

Top module: `cic_dec5x4`

## Requirements
- R1: While `rst_ni` is low, `res_o` reads 0 and `res_vld_o` reads 0, whatever the input is doing. Reset also clears every integrator, comb delay and the decimation counter, so filtering afterwards starts from an all-zero state.
- R2: A sample is taken only on a rising edge where `smp_vld_i` is 1. The value on `smp_i` during cycles without the strobe has no effect on any later output.
- R3: One result is produced for every four accepted samples, on the 4th, 8th, 12th and so on. Only strobed samples count, so idle cycles between samples do not move the decimation phase.
- R4: The result is bit-exact. There are five cascaded 28-bit wrapping accumulators, each adding the new output of the stage before it. On every fourth sample the last accumulator value passes through five 28-bit wrapping first differences, and `res_o` equals bits 27:10 of the fifth difference.
- R5: `res_vld_o` is high for exactly one cycle per result and is low in the cycle that follows it.
- R6: `res_vld_o` rises on the 12th rising edge after the edge that accepted the sample completing a group of four.
- R7: `res_o` changes only on the edge that raises `res_vld_o` and holds its value in every other cycle.
- R8: After `rst_ni` rises, the first two rising edges still act as reset: strobed samples presented on them are not accepted. The first sample taken is the one on the third edge.
- R9: For a constant input held long enough to settle (20 samples or more), `res_o` equals the input value exactly. This holds at both ends of the range, +131071 and −131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all stages |
| rst_ni | input | 1 | Active-low reset; takes effect at once and is released synchronously inside the block |
| smp_i | input | 18 | Signed input sample |
| smp_vld_i | input | 1 | Marks `smp_i` as a sample to accept |
| res_o | output | 18 | Signed decimated result |
| res_vld_o | output | 1 | One-cycle pulse marking a new `res_o` |

## Verification
A single full-scale impulse reveals the impulse response shape and any error in the comb subtraction order. Positive and negative full-scale constants test the exact gain of 1024 and the wrap headroom at both extremes of the range. A long run of back-to-back random samples exercises the pipelined integrators at their highest update rate, where an extra or missing stage delay would corrupt every result. A second random run drops the strobe about half the time and drives junk data in the idle cycles. This separates a design that counts strobed samples from one that counts clock cycles or lets idle data leak in. Every result is also timed against the 12-edge latency.

// File: rtl/cic_dec_pkg.sv
package cic_dec_pkg;

  // Accumulator width needed so that the integrator wrap is harmless:
  // input width grown by log2(rate) bits for each stage of the cascade.
  function automatic int unsigned acc_width(int unsigned in_w,
                                            int unsigned order,
                                            int unsigned rate);
    return in_w + order * $clog2(rate);
  endfunction

endpackage

// File: rtl/cic_rst_sync.sv
// Asserts at once, releases after STAGES rising edges.
module cic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cic_integ_stage.sv
// One registered running-sum stage; wraps modulo 2^W.
module cic_integ_stage #(
  parameter int unsigned W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] acc_o,
  output logic         vld_o
);

  logic [W-1:0] acc_q, acc_d;
  logic         vld_q, vld_d;

  always_comb begin
    acc_d = acc_q;
    if (en_i) begin
      acc_d = acc_q + x_i;
    end
    vld_d = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      vld_q <= vld_d;
    end
  end

  assign acc_o = acc_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/cic_decim_gate.sv
// Counts qualified inputs and passes on every RATE-th one.
module cic_decim_gate #(
  parameter int unsigned W    = 28,
  parameter int unsigned RATE = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] smp_o,
  output logic         stb_o
);

  localparam int unsigned CNT_W = $clog2(RATE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     smp_q, smp_d;
  logic             stb_q, stb_d;

  always_comb begin
    cnt_d = cnt_q;
    smp_d = smp_q;
    stb_d = 1'b0;
    if (en_i) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        smp_d = x_i;
        stb_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      smp_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      smp_q <= smp_d;
      stb_q <= stb_d;
    end
  end

  assign smp_o = smp_q;
  assign stb_o = stb_q;

endmodule

// File: rtl/cic_comb_stage.sv
// One registered first-difference stage, stepped only by its strobe.
module cic_comb_stage #(
  parameter int unsigned W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o,
  output logic         vld_o
);

  logic [W-1:0] dly_q, dly_d;
  logic [W-1:0] y_q, y_d;
  logic         vld_q, vld_d;

  always_comb begin
    dly_d = dly_q;
    y_d   = y_q;
    if (en_i) begin
      y_d   = x_i - dly_q;
      dly_d = x_i;
    end
    vld_d = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      dly_q <= dly_d;
      y_q   <= y_d;
      vld_q <= vld_d;
    end
  end

  assign y_o   = y_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/cic_dec5x4.sv
// Pipelined CIC decimator: input flop, ORDER integrators, decimation
// gate, ORDER combs, output flop. Latency 2*ORDER+2 edges.
module cic_dec5x4 #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned OUT_W = 18,
  parameter int unsigned RATE  = 4,
  parameter int unsigned ORDER = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  smp_i,
  input  logic             smp_vld_i,
  output logic [OUT_W-1:0] res_o,
  output logic             res_vld_o
);

  localparam int unsigned ACC_W  = cic_dec_pkg::acc_width(IN_W, ORDER, RATE);
  localparam int unsigned EXT_W  = ACC_W - IN_W;
  localparam int unsigned DROP_W = ACC_W - OUT_W;

  logic rst_int_n;

  cic_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  // Input register.
  logic [ACC_W-1:0] in_q, in_d;
  logic             in_v_q, in_v_d;

  always_comb begin
    in_d   = in_q;
    if (smp_vld_i) begin
      in_d = {{EXT_W{smp_i[IN_W-1]}}, smp_i};
    end
    in_v_d = smp_vld_i;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      in_q   <= '0;
      in_v_q <= 1'b0;
    end else begin
      in_q   <= in_d;
      in_v_q <= in_v_d;
    end
  end

  // Integrator cascade.
  logic [ACC_W-1:0] int_dat [ORDER+1];
  logic             int_vld [ORDER+1];

  assign int_dat[0] = in_q;
  assign int_vld[0] = in_v_q;

  for (genvar g = 0; g < ORDER; g++) begin : g_integ
    cic_integ_stage #(.W(ACC_W)) u_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .en_i   (int_vld[g]),
      .x_i    (int_dat[g]),
      .acc_o  (int_dat[g+1]),
      .vld_o  (int_vld[g+1])
    );
  end

  // Rate reduction.
  logic [ACC_W-1:0] cmb_dat [ORDER+1];
  logic             cmb_vld [ORDER+1];

  cic_decim_gate #(.W(ACC_W), .RATE(RATE)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (int_vld[ORDER]),
    .x_i    (int_dat[ORDER]),
    .smp_o  (cmb_dat[0]),
    .stb_o  (cmb_vld[0])
  );

  // Comb cascade at the reduced rate.
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    cic_comb_stage #(.W(ACC_W)) u_comb (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .en_i   (cmb_vld[g]),
      .x_i    (cmb_dat[g]),
      .y_o    (cmb_dat[g+1]),
      .vld_o  (cmb_vld[g+1])
    );
  end

  // Output register: top OUT_W bits remove the cascade gain.
  logic [OUT_W-1:0] res_q, res_d;
  logic             res_v_q, res_v_d;

  always_comb begin
    res_d   = res_q;
    if (cmb_vld[ORDER]) begin
      res_d = OUT_W'(cmb_dat[ORDER] >> DROP_W);
    end
    res_v_d = cmb_vld[ORDER];
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q   <= '0;
      res_v_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      res_v_q <= res_v_d;
    end
  end

  assign res_o     = res_q;
  assign res_vld_o = res_v_q;

endmodule

// File: rtl/cic_dec5x4_chk.sv
module cic_dec5x4_chk #(
  parameter int unsigned OUT_W = 18,
  parameter int unsigned RATE  = 4,
  parameter int unsigned ORDER = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_vld_i,
  input logic [OUT_W-1:0] res_o,
  input logic             res_vld_o
);

  // Edges from accepting a sample to sampling the raised valid.
  localparam int unsigned LAT   = 2 * ORDER + 3;
  localparam int unsigned GAP_W = $clog2(RATE + 1);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(RATE);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_MIN;
    end else if (res_vld_o) begin
      gap_q <= GAP_W'(1);
    end else if (gap_q != GAP_MIN) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |=> !res_vld_o); // R5

  AST_RES_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> $stable(res_o)); // R7

  AST_LATENCY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> $past(smp_vld_i, LAT)); // R6

  AST_DECIM_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> (gap_q >= GAP_MIN)); // R3

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!res_vld_o && (res_o == '0))); // R1

endmodule

bind cic_dec5x4 cic_dec5x4_chk #(
  .OUT_W (OUT_W),
  .RATE  (RATE),
  .ORDER (ORDER)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_vld_i (smp_vld_i),
  .res_o     (res_o),
  .res_vld_o (res_vld_o)
);

// File: tb/cic_dec5x4_tb.sv
module cic_dec5x4_tb;

  localparam int LAT = 12;

  logic        clk;
  logic        rst_n;
  logic [17:0] smp;
  logic        smp_vld;
  logic [17:0] res;
  logic        res_vld;

  cic_dec5x4 u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .smp_i     (smp),
    .smp_vld_i (smp_vld),
    .res_o     (res),
    .res_vld_o (res_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state.
  logic [27:0] m_int [5];
  logic [27:0] m_dly [5];
  int          m_cnt = 0;
  int          n_acc = 0;

  logic [17:0] exp_val [4096];
  int          exp_edge[4096];
  string       exp_tag [4096];
  int          n_exp = 0;
  int          n_got = 0;

  string cur_tag = "R4";

  task automatic model_push(input logic [17:0] x, input int edge_no);
    logic [27:0] v, t;
    m_int[0] = m_int[0] + {{10{x[17]}}, x};
    for (int k = 1; k < 5; k++) m_int[k] = m_int[k] + m_int[k-1];
    n_acc++;
    m_cnt++;
    if (m_cnt == 4) begin
      m_cnt = 0;
      v = m_int[4];
      for (int k = 0; k < 5; k++) begin
        t = v - m_dly[k];
        m_dly[k] = v;
        v = t;
      end
      exp_val[n_exp]  = v[27:10];
      exp_edge[n_exp] = edge_no + LAT;
      exp_tag[n_exp]  = cur_tag;
      n_exp++;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Drive one cycle; sample is accepted at the edge before the next negedge.
  task automatic send(input logic v, input logic [17:0] d, input bit counts);
    smp_vld = v;
    smp     = d;
    @(negedge clk);
    if (v && counts) model_push(d, cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 18'($urandom), 1'b0);
  endtask

  // Output monitor.
  logic        prev_vld = 1'b0;
  logic [17:0] last_res = '0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (res_vld) begin
        if (n_got < n_exp) begin
          check(res == exp_val[n_got], exp_tag[n_got], "result value",
                longint'($signed(res)), longint'($signed(exp_val[n_got])));
          check(cyc == exp_edge[n_got], "R6", "result edge",
                cyc, exp_edge[n_got]);
        end else begin
          check(1'b0, "R3", "unexpected result count", n_got + 1, n_exp);
        end
        n_got++;
        check(!prev_vld, "R5", "valid high two cycles", 1, 0);
      end else begin
        check(res == last_res, "R7", "result moved without valid",
              longint'($signed(res)), longint'($signed(last_res)));
      end
      prev_vld = res_vld;
      last_res = res;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Watchdog.
  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual_cycles=%0d expected_below=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 5; k++) begin
      m_int[k] = '0;
      m_dly[k] = '0;
    end
    rst_n   = 1'b1;
    smp     = '0;
    smp_vld = 1'b0;
    #5 rst_n = 1'b0;

    // R1: held in reset while strobed junk arrives.
    for (int i = 0; i < 6; i++) begin
      smp_vld = 1'b1;
      smp     = 18'($urandom);
      @(negedge clk);
      check(res == 0 && res_vld == 0, "R1", "output during reset",
            longint'({res_vld, res}), 0);
    end

    // R8: release, first two edges must not accept samples.
    smp_vld = 1'b0;
    rst_n   = 1'b1;
    send(1'b1, 18'h1FFFF, 1'b0);
    send(1'b1, 18'h1FFFF, 1'b0);
    cur_tag = "R8";
    for (int i = 0; i < 8; i++) send(1'b1, 18'(i * 1000), 1'b1);
    check(res == 0 && res_vld == 0, "R1", "output right after release",
          longint'({res_vld, res}), 0);

    // Impulse.
    cur_tag = "R4";
    send(1'b1, 18'h1FFFF, 1'b1);
    for (int i = 0; i < 63; i++) send(1'b1, 18'h0, 1'b1);

    // R9: full-scale constants, both signs.
    cur_tag = "R9";
    for (int i = 0; i < 64; i++) send(1'b1, 18'h1FFFF, 1'b1);
    idle(LAT + 4);
    check($signed(res) == 131071, "R9", "positive constant",
          longint'($signed(res)), 131071);
    for (int i = 0; i < 64; i++) send(1'b1, 18'h20000, 1'b1);
    idle(LAT + 4);
    check($signed(res) == -131072, "R9", "negative constant",
          longint'($signed(res)), -131072);

    // Back-to-back random samples.
    cur_tag = "R4";
    for (int i = 0; i < 800; i++) send(1'b1, 18'($urandom), 1'b1);

    // R2/R3: strobe dropped about half the time, junk in idle cycles.
    cur_tag = "R2";
    for (int i = 0; i < 1600; i++) begin
      logic v;
      v = 1'($urandom);
      send(v, 18'($urandom), 1'b1);
    end

    idle(LAT + 8);
    check(n_got == n_exp, "R3", "result count", n_got, n_exp);
    check(n_exp == n_acc / 4, "R3", "results per accepted samples",
          n_exp, n_acc / 4);
    finish_run();
  end

endmodule